// File: doc/BRIEF.md
# Multi-PID Variable-Page Translation Matcher

This block translates an effective address through a small, software-written array of translation entries. Each entry carries a valid flag, a 5-bit page-size code (page = 1 KB shifted left by the code), a translation ID, an address-space flag, an effective page number, a real page number, and two permission triples: one for supervisor and one for user. One write port loads a whole entry at a time.

A lookup gives the address, the access kind (fetch, read or write), the privilege mode, the instruction and data address-space flags, and three process IDs. All entries are evaluated in parallel. The entry with the lowest index whose outcome is anything other than "no match" decides the result. One cycle after the request the block returns a result code, the physical address and the effective permissions of that entry.

Top module: `xlat_matcher`

## Requirements
- R1: An entry covers a page of 1024 << size bytes. The address bits at and above log2(page size) take part in the compare. If the page is as large as the address space or larger, every address falls inside it.
- R2: An entry whose valid flag is clear never matches. After reset all entries are invalid.
- R3: An entry's translation ID matches in three cases: it is zero; it equals pid0_i; or it equals a nonzero pid1_i or pid2_i.
- R4: An entry matches only when the address and the EPN agree in all page-number bits. EPN bits below the page are ignored. On a match, paddr_o takes the RPN's page-number bits and the address's in-page offset bits.
- R5: perm_o bit 0 is read, bit 1 is write and bit 2 is execute. They come from the user triple when user_i is 1 and from the supervisor triple otherwise.
- R6: The entry's address-space flag must equal ias_i for a fetch and das_i for a read or write. A mismatch is a no match.
- R7: kind_i encodes 0 = fetch, 1 = read, 2 = write; 3 behaves as a read. res_o encodes 0 = granted, 1 = no match, 2 = read/write permission denied, 3 = execute permission denied. A fetch needs the execute bit, a read the read bit, a write the write bit.
- R8: The lowest-index entry whose outcome is not "no match" decides res_o, paddr_o and perm_o. Entries above it are ignored, even if they would grant.
- R9: On no match, paddr_o and perm_o are zero.
- R10: rsp_valid_o pulses one cycle after each req_i. The outputs hold until the next response. A lookup issued in the same cycle as an entry write sees the old contents. At reset rsp_valid_o is 0 and res_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one entry |
| wr_idx_i | input | IW | Entry index to write |
| wr_valid_i | input | 1 | Valid flag to write |
| wr_size_i | input | SZ_W | Page-size code |
| wr_tid_i | input | TID_W | Translation ID |
| wr_as_i | input | 1 | Address-space flag |
| wr_epn_i | input | AW | Effective page number (address-aligned) |
| wr_rpn_i | input | AW | Real page number (address-aligned) |
| wr_sperm_i | input | 3 | Supervisor {X,W,R} |
| wr_uperm_i | input | 3 | User {X,W,R} |
| req_i | input | 1 | Lookup request |
| addr_i | input | AW | Effective address |
| kind_i | input | 2 | Access kind |
| user_i | input | 1 | 1 = user mode |
| ias_i | input | 1 | Instruction address space |
| das_i | input | 1 | Data address space |
| pid0_i | input | TID_W | Primary process ID |
| pid1_i | input | TID_W | Second process ID, 0 = unused |
| pid2_i | input | TID_W | Third process ID, 0 = unused |
| rsp_valid_o | output | 1 | Response strobe |
| res_o | output | 2 | Result code |
| paddr_o | output | AW | Physical address |
| perm_o | output | 3 | Effective {X,W,R} |

## Verification
Every lookup result is registered once, so it appears at the first rising edge after the request. The bench drives each request on a falling edge and reads the outputs on the next falling edge, half a cycle after they settle. Entry writes are applied the same way, and the write-then-lookup order is checked against that one-edge latency. The lookup sweeps compare against an arithmetic model that divides addresses by the page size.

// File: rtl/xlat_matcher_pkg.sv
package xlat_matcher_pkg;
  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_W_BIT = 1;
  localparam int PERM_X = 2;
  localparam int PAGE_MIN_LOG2 = 10;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;

  typedef enum logic [1:0] {
    RES_GRANT   = 2'd0,
    RES_MISS    = 2'd1,
    RES_RW_DENY = 2'd2,
    RES_X_DENY  = 2'd3
  } res_e;
endpackage

// File: rtl/xlat_entry_file.sv
module xlat_entry_file
  import xlat_matcher_pkg::*;
#(
  parameter int N     = 4,
  parameter int AW    = 32,
  parameter int SZ_W  = 5,
  parameter int TID_W = 8,
  localparam int IW   = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [SZ_W-1:0]   wr_size_i,
  input  logic [TID_W-1:0]  wr_tid_i,
  input  logic              wr_as_i,
  input  logic [AW-1:0]     wr_epn_i,
  input  logic [AW-1:0]     wr_rpn_i,
  input  logic [PERM_W-1:0] wr_sperm_i,
  input  logic [PERM_W-1:0] wr_uperm_i,
  output logic              valid_o [N],
  output logic [SZ_W-1:0]   size_o  [N],
  output logic [TID_W-1:0]  tid_o   [N],
  output logic              as_o    [N],
  output logic [AW-1:0]     epn_o   [N],
  output logic [AW-1:0]     rpn_o   [N],
  output logic [PERM_W-1:0] sperm_o [N],
  output logic [PERM_W-1:0] uperm_o [N]
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        size_o[i]  <= '0;
        tid_o[i]   <= '0;
        as_o[i]    <= 1'b0;
        epn_o[i]   <= '0;
        rpn_o[i]   <= '0;
        sperm_o[i] <= '0;
        uperm_o[i] <= '0;
      end else if (wr_en_i && (wr_idx_i == IW'(i))) begin
        valid_o[i] <= wr_valid_i;
        size_o[i]  <= wr_size_i;
        tid_o[i]   <= wr_tid_i;
        as_o[i]    <= wr_as_i;
        epn_o[i]   <= wr_epn_i;
        rpn_o[i]   <= wr_rpn_i;
        sperm_o[i] <= wr_sperm_i;
        uperm_o[i] <= wr_uperm_i;
      end
    end
  end
endmodule

// File: rtl/xlat_entry_check.sv
module xlat_entry_check
  import xlat_matcher_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SZ_W  = 5,
  parameter int TID_W = 8
) (
  input  logic              e_valid_i,
  input  logic [SZ_W-1:0]   e_size_i,
  input  logic [TID_W-1:0]  e_tid_i,
  input  logic              e_as_i,
  input  logic [AW-1:0]     e_epn_i,
  input  logic [AW-1:0]     e_rpn_i,
  input  logic [PERM_W-1:0] e_sperm_i,
  input  logic [PERM_W-1:0] e_uperm_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [1:0]        kind_i,
  input  logic              user_i,
  input  logic              ias_i,
  input  logic              das_i,
  input  logic [TID_W-1:0]  pid0_i,
  input  logic [TID_W-1:0]  pid1_i,
  input  logic [TID_W-1:0]  pid2_i,
  output res_e              res_o,
  output logic [AW-1:0]     paddr_o,
  output logic [PERM_W-1:0] perm_o
);
  logic [AW-1:0] page_mask;
  logic pid_hit, addr_hit, as_hit, hit;

  always_comb begin
    for (int b = 0; b < AW; b++) begin
      page_mask[b] = (b >= PAGE_MIN_LOG2 + int'(e_size_i));
    end
  end

  // zero TID is a wildcard; PID1/PID2 only take part when nonzero
  assign pid_hit = (e_tid_i == '0) || (e_tid_i == pid0_i) ||
                   ((pid1_i != '0) && (e_tid_i == pid1_i)) ||
                   ((pid2_i != '0) && (e_tid_i == pid2_i));
  assign addr_hit = ((addr_i ^ e_epn_i) & page_mask) == '0;
  assign as_hit   = e_as_i == ((kind_i == KIND_FETCH) ? ias_i : das_i);
  assign hit      = e_valid_i && pid_hit && addr_hit && as_hit;
  assign perm_o   = user_i ? e_uperm_i : e_sperm_i;
  assign paddr_o  = (e_rpn_i & page_mask) | (addr_i & ~page_mask);

  always_comb begin
    if (!hit)                    res_o = RES_MISS;
    else if (kind_i == KIND_FETCH) res_o = perm_o[PERM_X] ? RES_GRANT : RES_X_DENY;
    else if (kind_i == KIND_WRITE) res_o = perm_o[PERM_W_BIT] ? RES_GRANT : RES_RW_DENY;
    else                         res_o = perm_o[PERM_R] ? RES_GRANT : RES_RW_DENY;
  end
endmodule

// File: rtl/xlat_first_pick.sv
module xlat_first_pick
  import xlat_matcher_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32
) (
  input  res_e              res_i   [N],
  input  logic [AW-1:0]     paddr_i [N],
  input  logic [PERM_W-1:0] perm_i  [N],
  output res_e              res_o,
  output logic [AW-1:0]     paddr_o,
  output logic [PERM_W-1:0] perm_o
);
  logic done;
  always_comb begin
    res_o   = RES_MISS;
    paddr_o = '0;
    perm_o  = '0;
    done    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!done && res_i[i] != RES_MISS) begin
        res_o   = res_i[i];
        paddr_o = (res_i[i] == RES_GRANT) ? paddr_i[i] : '0;
        perm_o  = perm_i[i];
        done    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_matcher.sv
module xlat_matcher
  import xlat_matcher_pkg::*;
#(
  parameter int N     = 4,
  parameter int AW    = 32,
  parameter int SZ_W  = 5,
  parameter int TID_W = 8,
  localparam int IW   = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [SZ_W-1:0]   wr_size_i,
  input  logic [TID_W-1:0]  wr_tid_i,
  input  logic              wr_as_i,
  input  logic [AW-1:0]     wr_epn_i,
  input  logic [AW-1:0]     wr_rpn_i,
  input  logic [2:0]        wr_sperm_i,
  input  logic [2:0]        wr_uperm_i,
  input  logic              req_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [1:0]        kind_i,
  input  logic              user_i,
  input  logic              ias_i,
  input  logic              das_i,
  input  logic [TID_W-1:0]  pid0_i,
  input  logic [TID_W-1:0]  pid1_i,
  input  logic [TID_W-1:0]  pid2_i,
  output logic              rsp_valid_o,
  output logic [1:0]        res_o,
  output logic [AW-1:0]     paddr_o,
  output logic [2:0]        perm_o
);
  logic              e_valid [N];
  logic [SZ_W-1:0]   e_size  [N];
  logic [TID_W-1:0]  e_tid   [N];
  logic              e_as    [N];
  logic [AW-1:0]     e_epn   [N];
  logic [AW-1:0]     e_rpn   [N];
  logic [PERM_W-1:0] e_sperm [N];
  logic [PERM_W-1:0] e_uperm [N];

  res_e              c_res   [N];
  logic [AW-1:0]     c_paddr [N];
  logic [PERM_W-1:0] c_perm  [N];

  res_e              sel_res;
  logic [AW-1:0]     sel_paddr;
  logic [PERM_W-1:0] sel_perm;

  xlat_entry_file #(.N(N), .AW(AW), .SZ_W(SZ_W), .TID_W(TID_W)) u_file (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_size_i, .wr_tid_i,
    .wr_as_i, .wr_epn_i, .wr_rpn_i, .wr_sperm_i, .wr_uperm_i,
    .valid_o(e_valid), .size_o(e_size), .tid_o(e_tid), .as_o(e_as),
    .epn_o(e_epn), .rpn_o(e_rpn), .sperm_o(e_sperm), .uperm_o(e_uperm)
  );

  for (genvar i = 0; i < N; i++) begin : g_chk
    xlat_entry_check #(.AW(AW), .SZ_W(SZ_W), .TID_W(TID_W)) u_chk (
      .e_valid_i(e_valid[i]), .e_size_i(e_size[i]), .e_tid_i(e_tid[i]),
      .e_as_i(e_as[i]), .e_epn_i(e_epn[i]), .e_rpn_i(e_rpn[i]),
      .e_sperm_i(e_sperm[i]), .e_uperm_i(e_uperm[i]),
      .addr_i, .kind_i, .user_i, .ias_i, .das_i, .pid0_i, .pid1_i, .pid2_i,
      .res_o(c_res[i]), .paddr_o(c_paddr[i]), .perm_o(c_perm[i])
    );
  end

  xlat_first_pick #(.N(N), .AW(AW)) u_pick (
    .res_i(c_res), .paddr_i(c_paddr), .perm_i(c_perm),
    .res_o(sel_res), .paddr_o(sel_paddr), .perm_o(sel_perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      res_o       <= RES_MISS;
      paddr_o     <= '0;
      perm_o      <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        res_o   <= sel_res;
        paddr_o <= sel_paddr;
        perm_o  <= sel_perm;
      end
    end
  end
endmodule

// File: rtl/xlat_matcher_chk.sv
module xlat_matcher_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    kind_i,
  input logic          rsp_valid_o,
  input logic [1:0]    res_o,
  input logic [AW-1:0] paddr_o,
  input logic [2:0]    perm_o
);
  p_rsp_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  p_no_spurious_rsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(res_o) && $stable(paddr_o) && $stable(perm_o)));
  p_miss_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && res_o == 2'd1) |-> (paddr_o == '0 && perm_o == '0));
  p_xdeny_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (res_o != 2'd3 || $past(kind_i) == 2'd0));
  p_rwdeny_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (res_o != 2'd2 || $past(kind_i) != 2'd0));
  p_fetch_grant_x_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'd0) |=> (res_o != 2'd0 || perm_o[2]));
  p_offset_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (res_o != 2'd0 || paddr_o[9:0] == $past(addr_i[9:0])));
endmodule

bind xlat_matcher xlat_matcher_chk #(.AW(AW)) u_xlat_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
  .kind_i(kind_i), .rsp_valid_o(rsp_valid_o), .res_o(res_o),
  .paddr_o(paddr_o), .perm_o(perm_o)
);

// File: tb/xlat_matcher_tb.sv
module xlat_matcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int SZ_W = 5;
  localparam int TID_W = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0; logic [IW-1:0] wr_idx = 0; logic wr_valid = 0;
  logic [SZ_W-1:0] wr_size = 0; logic [TID_W-1:0] wr_tid = 0; logic wr_as = 0;
  logic [AW-1:0] wr_epn = 0, wr_rpn = 0; logic [2:0] wr_sperm = 0, wr_uperm = 0;
  logic req = 0; logic [AW-1:0] addr = 0; logic [1:0] kind = 0;
  logic user = 0, ias = 0, das = 0;
  logic [TID_W-1:0] pid0 = 0, pid1 = 0, pid2 = 0;
  logic rsp_valid; logic [1:0] res; logic [AW-1:0] paddr; logic [2:0] perm;

  int checks = 0, errors = 0;
  bit finished = 0;

  bit              m_v   [N];
  int unsigned     m_sz  [N];
  int unsigned     m_tid [N];
  bit              m_as  [N];
  longint unsigned m_epn [N];
  longint unsigned m_rpn [N];
  logic [2:0]      m_sp  [N];
  logic [2:0]      m_up  [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_matcher #(.N(N), .AW(AW), .SZ_W(SZ_W), .TID_W(TID_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_valid_i(wr_valid), .wr_size_i(wr_size), .wr_tid_i(wr_tid), .wr_as_i(wr_as),
    .wr_epn_i(wr_epn), .wr_rpn_i(wr_rpn), .wr_sperm_i(wr_sperm), .wr_uperm_i(wr_uperm),
    .req_i(req), .addr_i(addr), .kind_i(kind), .user_i(user), .ias_i(ias), .das_i(das),
    .pid0_i(pid0), .pid1_i(pid1), .pid2_i(pid2),
    .rsp_valid_o(rsp_valid), .res_o(res), .paddr_o(paddr), .perm_o(perm)
  );

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input bit v, input int sz, input int tid, input bit as_b,
                     input longint unsigned epn, input longint unsigned rpn,
                     input logic [2:0] sp, input logic [2:0] up, input bit with_req = 0);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(i); wr_valid = v; wr_size = SZ_W'(sz); wr_tid = TID_W'(tid);
    wr_as = as_b; wr_epn = AW'(epn); wr_rpn = AW'(rpn); wr_sperm = sp; wr_uperm = up;
    req = with_req;
    @(negedge clk);
    wr_en = 0; req = 0;
    m_v[i] = v; m_sz[i] = sz; m_tid[i] = tid; m_as[i] = as_b;
    m_epn[i] = epn & 32'hFFFF_FFFF; m_rpn[i] = rpn & 32'hFFFF_FFFF; m_sp[i] = sp; m_up[i] = up;
  endtask

  task automatic look(input longint unsigned a, input int kd, input bit u, input bit ia,
                      input bit da, input int p0, input int p1, input int p2);
    @(negedge clk);
    req = 1; addr = AW'(a); kind = 2'(kd); user = u; ias = ia; das = da;
    pid0 = TID_W'(p0); pid1 = TID_W'(p1); pid2 = TID_W'(p2);
    @(negedge clk);
    req = 0;
    chk("R10 rsp_valid", rsp_valid, 1);
  endtask

  function automatic void ref_lk(input longint unsigned a, input int kd, input bit u,
      input bit ia, input bit da, input int p0, input int p1, input int p2,
      output int rc, output longint unsigned pa, output logic [2:0] pm);
    rc = 1; pa = 0; pm = 0;
    for (int i = 0; i < N; i++) begin
      longint unsigned sz;
      bit pid_ok, a_ok, as_ok;
      sz = 64'd1024 << m_sz[i];
      if (!m_v[i]) continue;
      pid_ok = m_tid[i] == 0 || m_tid[i] == p0 || (p1 != 0 && m_tid[i] == p1) ||
               (p2 != 0 && m_tid[i] == p2);
      a_ok = (a / sz) == (m_epn[i] / sz);
      as_ok = m_as[i] == ((kd == 0) ? ia : da);
      if (!(pid_ok && a_ok && as_ok)) continue;
      pm = u ? m_up[i] : m_sp[i];
      if (kd == 0) rc = pm[2] ? 0 : 3;
      else if (kd == 2) rc = pm[1] ? 0 : 2;
      else rc = pm[0] ? 0 : 2;
      if (rc == 0) pa = ((m_rpn[i] / sz) * sz + a % sz) & 32'hFFFF_FFFF;
      return;
    end
  endfunction

  task automatic look_ref(input longint unsigned a, input int kd, input bit u, input bit ia,
                          input bit da, input int p0, input int p1, input int p2);
    int rc; longint unsigned pa; logic [2:0] pm;
    ref_lk(a, kd, u, ia, da, p0, p1, p2, rc, pa, pm);
    look(a, kd, u, ia, da, p0, p1, p2);
    chk("R7 res", res, rc);
    chk(rc == 1 ? "R9 paddr" : "R4 paddr", paddr, pa);
    chk(rc == 1 ? "R9 perm" : "R5 perm", perm, pm);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_sz[i] = 0; m_tid[i] = 0; m_as[i] = 0;
      m_epn[i] = 0; m_rpn[i] = 0; m_sp[i] = 0; m_up[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R10 reset rsp_valid", rsp_valid, 0);
    chk("R10 reset res", res, 1);
    rst_n = 1;
    // R2: empty after reset
    look(32'h0, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 empty miss", res, 1);

    // R1: 4 KB page, boundaries
    put(0, 1, 2, 0, 0, 64'h0000_3000, 64'hABCD_E000, 3'b111, 3'b000);
    look(64'h0000_3FFC, 1, 0, 0, 0, 0, 0, 0);
    chk("R1 in page", res, 0); chk("R4 paddr", paddr, 64'hABCD_EFFC);
    look(64'h0000_4000, 1, 0, 0, 0, 0, 0, 0);
    chk("R1 next page miss", res, 1);
    look(64'h0000_2FFF, 1, 0, 0, 0, 0, 0, 0);
    chk("R1 prev page miss", res, 1);
    // R1: page covering all of AW
    put(0, 1, 22, 0, 0, 64'h0, 64'hFFFF_F000, 3'b001, 3'b001);
    look(64'h1234_5678, 1, 0, 0, 0, 0, 0, 0);
    chk("R1 full space", res, 0); chk("R1 full paddr", paddr, 64'h1234_5678);
    put(0, 1, 31, 0, 0, 64'h0, 64'h0, 3'b001, 3'b001);
    look(64'hFEDC_BA98, 1, 0, 0, 0, 0, 0, 0);
    chk("R1 code31 paddr", paddr, 64'hFEDC_BA98);
    // R2: invalid entry
    put(0, 0, 31, 0, 0, 64'h0, 64'h0, 3'b111, 3'b111);
    look(64'h0, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 invalid miss", res, 1);

    // R3: translation ID vs three PIDs
    put(0, 1, 0, 5, 0, 64'h0001_0000, 64'h0002_0000, 3'b001, 3'b001);
    look(64'h0001_0010, 1, 0, 0, 0, 5, 0, 0); chk("R3 pid0", res, 0);
    look(64'h0001_0010, 1, 0, 0, 0, 3, 5, 0); chk("R3 pid1", res, 0);
    look(64'h0001_0010, 1, 0, 0, 0, 3, 0, 5); chk("R3 pid2", res, 0);
    look(64'h0001_0010, 1, 0, 0, 0, 3, 4, 6); chk("R3 no pid", res, 1);
    put(0, 1, 0, 0, 0, 64'h0001_0000, 64'h0002_0000, 3'b001, 3'b001);
    look(64'h0001_0010, 1, 0, 0, 0, 9, 7, 8); chk("R3 wildcard", res, 0);

    // R6: address space per access kind
    put(0, 1, 0, 0, 1, 64'h0001_0000, 64'h0002_0000, 3'b101, 3'b101);
    look(64'h0001_0000, 0, 0, 1, 0, 0, 0, 0); chk("R6 fetch ias", res, 0);
    look(64'h0001_0000, 0, 0, 0, 1, 0, 0, 0); chk("R6 fetch mismatch", res, 1);
    look(64'h0001_0000, 1, 0, 1, 0, 0, 0, 0); chk("R6 data mismatch", res, 1);
    look(64'h0001_0000, 1, 0, 0, 1, 0, 0, 0); chk("R6 data das", res, 0);

    // R8: first non-miss entry decides
    put(0, 1, 0, 0, 0, 64'h0005_0000, 64'h0006_0000, 3'b001, 3'b001);
    put(1, 1, 0, 0, 0, 64'h0005_0000, 64'h0007_0000, 3'b111, 3'b111);
    look(64'h0005_0004, 2, 0, 0, 0, 0, 0, 0);
    chk("R8 deny stops", res, 2); chk("R8 perm of first", perm, 3'b001);
    chk("R9 denied paddr", paddr, 0);
    look(64'h0005_0004, 1, 0, 0, 0, 0, 0, 0);
    chk("R8 first grants", paddr, 64'h0006_0004);
    put(0, 1, 0, 0, 1, 64'h0005_0000, 64'h0006_0000, 3'b001, 3'b001);
    look(64'h0005_0004, 2, 0, 0, 0, 0, 0, 0);
    chk("R8 skip miss", res, 0); chk("R8 second paddr", paddr, 64'h0007_0004);

    // R10: write and lookup in one cycle sees old contents
    addr = 32'h0009_0000; kind = 1; user = 0; ias = 0; das = 0; pid0 = 0; pid1 = 0; pid2 = 0;
    put(2, 1, 0, 0, 0, 64'h0009_0000, 64'h000A_0000, 3'b001, 3'b001, 1);
    chk("R10 old contents", res, 1);
    look(64'h0009_0000, 1, 0, 0, 0, 0, 0, 0);
    chk("R10 new contents", res, 0);
    // R7: kind 3 acts as read
    look(64'h0009_0000, 3, 0, 0, 0, 0, 0, 0);
    chk("R7 kind3 read", res, 0);

    // sweep against arithmetic model
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < N; i++)
        put(i, ((i + s) % 4) != 3, (i * 7 + s * 3) % 12, (i + s) % 3, ((i ^ s) & 1),
            64'h0040_0000 + longint'(i * s) * 64'h800,
            64'h8000_0000 + longint'(i) * 64'h0010_0000 + longint'(s) * 64'h1000,
            3'((i + s * 5) % 8), 3'((i * 3 + s) % 8));
      for (int k = 0; k < 8; k++)
        for (int kd = 0; kd < 3; kd++)
          for (int u = 0; u < 2; u++)
            for (int asv = 0; asv < 4; asv++)
              for (int ps = 0; ps < 4; ps++) begin
                int p0, p1, p2;
                p0 = (ps == 0) ? 1 : (ps == 1) ? 2 : (ps == 2) ? 0 : 3;
                p1 = (ps == 1) ? 1 : (ps == 3) ? 2 : 0;
                p2 = (ps == 2) ? 2 : (ps == 3) ? 1 : 0;
                look_ref(64'h0040_0000 + longint'(k) * 64'h600 + longint'(k) * 64'h2345,
                         kd, u[0], asv[0], asv[1], p0, p1, p2);
              end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule